// File: doc/BRIEF.md
# Dual-Clock FIFO with Standard and Fall-Through Read Styles

The block carries data words from a write port running on one clock to a read port running on an unrelated clock. Each side keeps its own binary pointer. Each pointer is converted to Gray code and passed through a chain of flip-flops into the opposite domain. Every flag is therefore computed only from values that are local to the clock of the port that the flag serves. A storage array sits between the two pointers, and a registered output stage presents the read data.

A mode pin is captured while reset is held and picks one of two read styles. In standard style, the read-side flag shows that memory is not empty, and an explicit read request copies the oldest word into the output register. In fall-through style, the same flag shows that the output register holds fresh data. The oldest word moves into that register without any request, and each read request consumes it. In both styles the word held in the output register is not counted as occupying memory, so its slot is free to be written again. Two threshold flags, almost-empty on the read side and almost-full on the write side, use offsets that are captured during reset.

Top module: `dual_clk_fifo`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises, the mode pin and both offsets are captured. After reset, `rd_avail` and `almost_empty_n` are 0, `wr_room` and `almost_full_n` are 1, and `rd_data` is 0.
- R2: In standard style (`fwft_sel`=0), `rd_avail` is 1 exactly when memory holds at least one word. A word written into an empty FIFO makes `rd_avail` rise on the second read-clock rising edge after the write edge, and not on the first.
- R3: In standard style, a read request on an edge where `rd_avail` is 1 loads the oldest stored word into `rd_data` on that edge. Words leave in the order they were written.
- R4: In either style, while `rd_avail` is 0, read requests are ignored and `rd_data` keeps its previous word.
- R5: In fall-through style (`fwft_sel`=1), a word written into an empty FIFO is loaded into `rd_data` with no read request. This happens on the third read-clock rising edge after the write edge, and `rd_avail` rises on that same edge.
- R6: In fall-through style, a read request while `rd_avail` is 1 consumes the held word. On the same edge the next stored word is loaded, or `rd_avail` falls to 0 if memory is empty.
- R7: The word held in the output register is not counted. In fall-through style, one held word plus DEPTH stored words are all accepted, and `wr_room` is then 0.
- R8: `wr_room` is 0 exactly when memory holds DEPTH words. A write request while `wr_room` is 0 is ignored and its data is lost.
- R9: `almost_full_n` is 0 when the write-side count is at least DEPTH minus `af_level`, and 1 below that count.
- R10: `almost_empty_n` is 0 when the read-side memory count is at most `ae_level`, and 1 above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| rd_clk | input | 1 | Read-port clock, asynchronous to wr_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_sel | input | 1 | Read style, captured at reset: 0 standard, 1 fall-through |
| ae_level | input | AW | Almost-empty offset, captured at reset |
| af_level | input | AW | Almost-full offset, captured at reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| wr_room | output | 1 | High when memory has room (full flag, active low) |
| almost_full_n | output | 1 | Low when the count reaches the almost-full threshold |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output register |
| rd_avail | output | 1 | Standard: memory not empty. Fall-through: output register valid |
| almost_empty_n | output | 1 | Low when the count is at or below the almost-empty offset |

## Verification
On every clock edge, the assertions check the following: a refused write leaves the write pointer unchanged, and the pointer never moves by more than one. A full flag always comes with an almost-full flag. `rd_data` cannot change while the read-side flag stays low. In standard style, almost-empty going high implies not-empty. Only the directed scenarios can show the rest. These are the exact two-edge and three-edge latencies of the two read styles, the order of the data, the precise almost-full and almost-empty thresholds, the loss of a word written while full, and the extra word that fall-through style holds outside the memory count.

// File: rtl/fifo_dc_pkg.sv
`timescale 1ns/1ps
package fifo_dc_pkg;
   typedef enum logic {
      RD_STD  = 1'b0,
      RD_FWFT = 1'b1
   } rd_style_e;
endpackage

// File: rtl/fifo_dc_sync.sv
`timescale 1ns/1ps
module fifo_dc_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fifo_dc_ram.sv
`timescale 1ns/1ps
module fifo_dc_ram #(
   parameter int DW = 16,
   parameter int AW = 4
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int WORDS = 1 << AW;
   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_dc_wr_side.sv
`timescale 1ns/1ps
module fifo_dc_wr_side #(
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] af_level,
   input  logic [AW:0]   rgray,
   output logic          wr_ok,
   output logic [AW:0]   wptr,
   output logic [AW:0]   wgray,
   output logic          wr_room,
   output logic          almost_full_n
);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] FULL_CNT = PW'(1 << AW);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] rsync_g, rsync_b, wptr_nx, cnt_nx;
   logic [AW-1:0] af_cfg;
   logic          run_q;

   fifo_dc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rsync_g)
   );

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   always_ff @(posedge wr_clk) begin
      if (!run_q) af_cfg <= af_level;
   end

   assign rsync_b = g2b(rsync_g);
   assign wr_ok   = wr_en & wr_room;
   assign wptr_nx = wptr + PW'(wr_ok);
   assign cnt_nx  = wptr_nx - rsync_b;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr          <= '0;
         wgray         <= '0;
         wr_room       <= 1'b1;
         almost_full_n <= 1'b1;
      end else begin
         wptr          <= wptr_nx;
         wgray         <= wptr_nx ^ (wptr_nx >> 1);
         wr_room       <= (cnt_nx != FULL_CNT);
         almost_full_n <= (cnt_nx < (FULL_CNT - PW'(af_cfg)));
      end
   end
endmodule

// File: rtl/fifo_dc_rd_side.sv
`timescale 1ns/1ps
module fifo_dc_rd_side
   import fifo_dc_pkg::*;
#(
   parameter int DW          = 16,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          fwft_sel,
   input  logic [AW-1:0] ae_level,
   input  logic          rd_en,
   input  logic [AW:0]   wgray,
   input  logic [DW-1:0] ram_rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] rd_data,
   output logic          rd_avail,
   output logic          almost_empty_n,
   output rd_style_e     style_q
);
   localparam int PW = AW + 1;

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] wsync_g, wsync_b, rptr, rptr_nx, mem_cnt;
   logic [AW-1:0] ae_cfg;
   logic          run_q, ready_q, mem_ne, take;

   fifo_dc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wsync_g)
   );

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   always_ff @(posedge rd_clk) begin
      if (!run_q) begin
         style_q <= rd_style_e'(fwft_sel);
         ae_cfg  <= ae_level;
      end
   end

   assign wsync_b = g2b(wsync_g);
   assign mem_cnt = wsync_b - rptr;
   assign mem_ne  = (mem_cnt != '0);
   assign rptr_nx = rptr + PW'(1);
   assign raddr   = rptr[AW-1:0];

   // Standard style loads on request; fall-through refills an empty or consumed register.
   always_comb begin
      if (style_q == RD_FWFT) take = mem_ne & (~ready_q | rd_en);
      else                    take = mem_ne & rd_en;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr    <= '0;
         rgray   <= '0;
         rd_data <= '0;
         ready_q <= 1'b0;
      end else begin
         if (take) begin
            rd_data <= ram_rdata;
            rptr    <= rptr_nx;
            rgray   <= rptr_nx ^ (rptr_nx >> 1);
         end
         if (style_q == RD_FWFT) begin
            if (take)       ready_q <= 1'b1;
            else if (rd_en) ready_q <= 1'b0;
         end else begin
            ready_q <= 1'b0;
         end
      end
   end

   assign rd_avail       = (style_q == RD_FWFT) ? ready_q : mem_ne;
   assign almost_empty_n = (mem_cnt > PW'(ae_cfg));
endmodule

// File: rtl/dual_clk_fifo.sv
`timescale 1ns/1ps
module dual_clk_fifo
   import fifo_dc_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH)
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              fwft_sel,
   input  logic [AW-1:0]     ae_level,
   input  logic [AW-1:0]     af_level,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_room,
   output logic              almost_full_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_avail,
   output logic              almost_empty_n
);
   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("dual_clk_fifo: DEPTH must be a power of two");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dual_clk_fifo: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              wr_ok;
   logic [AW:0]       wptr_w, wgray, rgray;
   logic [AW-1:0]     raddr;
   logic [DATA_W-1:0] ram_rdata;
   rd_style_e         rd_style;

   fifo_dc_wr_side #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_wr (
      .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .af_level(af_level),
      .rgray(rgray), .wr_ok(wr_ok), .wptr(wptr_w), .wgray(wgray),
      .wr_room(wr_room), .almost_full_n(almost_full_n)
   );

   fifo_dc_ram #(.DW(DATA_W), .AW(AW)) u_ram (
      .wr_clk(wr_clk), .we(wr_ok), .waddr(wptr_w[AW-1:0]), .wdata(wr_data),
      .raddr(raddr), .rdata(ram_rdata)
   );

   fifo_dc_rd_side #(.DW(DATA_W), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_rd (
      .rd_clk(rd_clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .ae_level(ae_level),
      .rd_en(rd_en), .wgray(wgray), .ram_rdata(ram_rdata), .raddr(raddr),
      .rgray(rgray), .rd_data(rd_data), .rd_avail(rd_avail),
      .almost_empty_n(almost_empty_n), .style_q(rd_style)
   );
endmodule

// File: rtl/fifo_dc_chk.sv
`timescale 1ns/1ps
module fifo_dc_chk
   import fifo_dc_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 4
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          wr_room,
   input logic          almost_full_n,
   input logic [AW:0]   wptr,
   input logic          rd_en,
   input logic          rd_avail,
   input logic          almost_empty_n,
   input logic [DW-1:0] rd_data,
   input rd_style_e     style_q
);
   // R8
   refused_write_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en && !wr_room) |=> $stable(wptr));

   // R8
   wptr_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      1'b1 |=> (wptr == $past(wptr) || wptr == $past(wptr) + 1'b1));

   // R9
   full_means_af_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !wr_room |-> !almost_full_n);

   // R4
   hold_when_idle_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_avail |=> ($stable(rd_data) || rd_avail));

   // R10
   std_ae_over_empty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (style_q == RD_STD && almost_empty_n) |-> rd_avail);
endmodule

bind dual_clk_fifo fifo_dc_chk #(.DW(DATA_W), .AW(AW)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
   .wr_room(wr_room), .almost_full_n(almost_full_n), .wptr(wptr_w),
   .rd_en(rd_en), .rd_avail(rd_avail), .almost_empty_n(almost_empty_n),
   .rd_data(rd_data), .style_q(rd_style)
);

// File: tb/tb_dual_clk_fifo.sv
`timescale 1ns/1ps
module tb_dual_clk_fifo;
   localparam int DW = 16;
   localparam int DEPTH = 16;
   localparam int AW = 4;

   logic          wr_clk, rd_clk, rst_n, fwft_sel, wr_en, rd_en;
   logic [AW-1:0] ae_level, af_level;
   logic [DW-1:0] wr_data, rd_data;
   logic          wr_room, almost_full_n, rd_avail, almost_empty_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   dual_clk_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_sel(fwft_sel),
      .ae_level(ae_level), .af_level(af_level), .wr_en(wr_en), .wr_data(wr_data),
      .wr_room(wr_room), .almost_full_n(almost_full_n), .rd_en(rd_en),
      .rd_data(rd_data), .rd_avail(rd_avail), .almost_empty_n(almost_empty_n)
   );

   // 50 MHz write clock; read clock 14 ns, offset so edges never coincide
   initial wr_clk = 0;
   always #10 wr_clk = ~wr_clk;
   initial begin
      rd_clk = 0;
      #2;
      forever #7 rd_clk = ~rd_clk;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic mode, input logic [AW-1:0] x, input logic [AW-1:0] y);
      rst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0;
      fwft_sel = mode; ae_level = x; af_level = y;
      repeat (3) @(posedge wr_clk);
      repeat (3) @(posedge rd_clk);
      @(negedge wr_clk);
      rst_n = 1;
      repeat (2) @(posedge wr_clk);
   endtask

   task automatic settle();
      repeat (10) @(posedge wr_clk);
   endtask

   task automatic wr_word(input logic [DW-1:0] d);
      @(negedge wr_clk);
      wr_en = 1; wr_data = d;
      @(posedge wr_clk);
      wr_en <= 0;
   endtask

   task automatic rd_word();
      @(negedge rd_clk);
      rd_en = 1;
      @(posedge rd_clk);
      rd_en <= 0;
      @(negedge rd_clk);
   endtask

   task automatic t_reset_state();
      do_reset(1'b0, 4'd3, 4'd4);
      chk("R1 rd_avail", 32'(rd_avail), 0);
      chk("R1 almost_empty_n", 32'(almost_empty_n), 0);
      chk("R1 wr_room", 32'(wr_room), 1);
      chk("R1 almost_full_n", 32'(almost_full_n), 1);
      chk("R1 rd_data", 32'(rd_data), 0);
   endtask

   task automatic t_std_latency_and_order();
      do_reset(1'b0, 4'd3, 4'd4);
      // R4: requests on an empty FIFO change nothing
      @(negedge rd_clk); rd_en = 1;
      repeat (3) @(posedge rd_clk);
      @(negedge rd_clk); rd_en = 0;
      chk("R4 std rd_data held", 32'(rd_data), 0);
      chk("R4 std rd_avail low", 32'(rd_avail), 0);
      // R2: flag rises on the second read edge after the write edge
      @(negedge wr_clk);
      wr_en = 1; wr_data = 16'hA1A1;
      @(posedge wr_clk);
      wr_en <= 0;
      @(posedge rd_clk); @(negedge rd_clk);
      chk("R2 low after 1st edge", 32'(rd_avail), 0);
      @(posedge rd_clk); @(negedge rd_clk);
      chk("R2 high after 2nd edge", 32'(rd_avail), 1);
      chk("R2 std no auto load", 32'(rd_data), 0);
      wr_word(16'hB2B2); wr_word(16'hC3C3); wr_word(16'hD4D4);
      settle();
      // R3: order preserved
      rd_word(); chk("R3 word0", 32'(rd_data), 32'h0000A1A1);
      rd_word(); chk("R3 word1", 32'(rd_data), 32'h0000B2B2);
      rd_word(); chk("R3 word2", 32'(rd_data), 32'h0000C3C3);
      rd_word(); chk("R3 word3", 32'(rd_data), 32'h0000D4D4);
      chk("R2 empty after drain", 32'(rd_avail), 0);
      rd_word();
      chk("R4 extra read ignored", 32'(rd_data), 32'h0000D4D4);
   endtask

   task automatic t_std_thresholds();
      do_reset(1'b0, 4'd3, 4'd4);
      for (int i = 0; i < 11; i++) wr_word(16'(100 + i));
      settle();
      chk("R9 11 words af high", 32'(almost_full_n), 1);
      wr_word(16'd111);
      @(negedge wr_clk);
      chk("R9 12 words af low", 32'(almost_full_n), 0);
      chk("R8 room at 12", 32'(wr_room), 1);
      for (int i = 12; i < 16; i++) wr_word(16'(100 + i));
      @(negedge wr_clk);
      chk("R8 full at DEPTH", 32'(wr_room), 0);
      wr_word(16'd999);
      @(negedge wr_clk);
      chk("R8 still full", 32'(wr_room), 0);
      settle();
      chk("R10 16 words ae high", 32'(almost_empty_n), 1);
      for (int i = 0; i < 16; i++) begin
         rd_word();
         chk("R8 drain data", 32'(rd_data), 32'(100 + i));
         chk("R10 ae level", 32'(almost_empty_n), ((15 - i) > 3) ? 32'd1 : 32'd0);
      end
      chk("R8 dropped word absent", 32'(rd_avail), 0);
   endtask

   task automatic t_fwft();
      do_reset(1'b1, 4'd3, 4'd4);
      chk("R1 fwft rd_avail", 32'(rd_avail), 0);
      @(negedge wr_clk);
      wr_en = 1; wr_data = 16'h0E0E;
      @(posedge wr_clk);
      wr_en <= 0;
      @(posedge rd_clk); @(negedge rd_clk);
      chk("R5 low after 1st edge", 32'(rd_avail), 0);
      @(posedge rd_clk); @(negedge rd_clk);
      chk("R5 low after 2nd edge", 32'(rd_avail), 0);
      chk("R5 data not yet loaded", 32'(rd_data), 0);
      @(posedge rd_clk); @(negedge rd_clk);
      chk("R5 high after 3rd edge", 32'(rd_avail), 1);
      chk("R5 word fell through", 32'(rd_data), 32'h00000E0E);
      wr_word(16'h0F0F); wr_word(16'h1010);
      settle();
      chk("R6 head held", 32'(rd_data), 32'h00000E0E);
      rd_word();
      chk("R6 next loaded", 32'(rd_data), 32'h00000F0F);
      chk("R6 still ready", 32'(rd_avail), 1);
      rd_word();
      chk("R6 last loaded", 32'(rd_data), 32'h00001010);
      rd_word();
      chk("R6 ready drops", 32'(rd_avail), 0);
      chk("R4 fwft data held", 32'(rd_data), 32'h00001010);
      rd_word();
      chk("R4 fwft idle read ignored", 32'(rd_data), 32'h00001010);
   endtask

   task automatic t_fwft_extra_word();
      do_reset(1'b1, 4'd3, 4'd4);
      wr_word(16'd200);
      settle();
      for (int i = 1; i <= DEPTH; i++) wr_word(16'(200 + i));
      settle();
      chk("R7 full with held word", 32'(wr_room), 0);
      chk("R7 held word", 32'(rd_data), 32'd200);
      for (int i = 1; i <= DEPTH; i++) begin
         rd_word();
         chk("R7 stored word", 32'(rd_data), 32'(200 + i));
      end
   endtask

   initial begin
      t_reset_state();
      t_std_latency_and_order();
      t_std_thresholds();
      t_fwft();
      t_fwft_extra_word();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule